// File: doc/BRIEF.md
# Serial Receive Queue with Trigger and Acceptance Levels

This block is the receive half of a buffered serial port. The line-side shifter hands it one byte at a time through a strobe. The block holds up to sixteen bytes in arrival order, and software drains them one at a time through a small word-wide register bus. The block drops a byte that finds the queue full and records the loss in a sticky overrun bit. Reading that bit clears it.

Two programmable levels, both set in the control register, shape the outputs. The trigger level decides when software sees a "queue full enough" flag instead of a plain "data present" flag. The acceptance limit drives a ready output for flow control toward the line side. The limit advises the line side only: a byte that arrives while ready is low is still stored if a slot is free. All flags follow the current fill count, so they change on the same clock edge that changes the count.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the queue is empty, `data_ready`, `rx_full_flag` and the overrun bit are 0, the control register reads 0, and `rx_ready` is 1.
- R2: A bus read at address 3 returns the oldest stored byte in bits 7:0 and removes it from the queue. A read at address 3 while the queue is empty returns 0 and leaves the queue unchanged.
- R3: A byte strobed in while 16 bytes are stored is discarded, the count stays at 16, and bit 0 of the line status register (address 2) becomes 1.
- R4: A read at address 2 returns the overrun bit and clears it. If a new overrun occurs in the same cycle as that read, the bit stays set.
- R5: Control bits 7:6 select the trigger level: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. While the count is at or above the trigger level, `rx_full_flag` is 1 and `data_ready` is 0.
- R6: While the count is below the trigger level, `rx_full_flag` is 0 and `data_ready` is 1 exactly when the count is nonzero.
- R7: Control bits 10:8 select the acceptance limit: 0 selects 15, 1 selects 1, and a value k from 2 to 7 selects 2k. `rx_ready` is 1 exactly when the count is below the limit. A byte is still stored while `rx_ready` is 0, unless the queue is full.
- R8: A push or pop updates `data_ready`, `rx_full_flag` and `rx_ready` on the same clock edge that changes the count. A control write updates them on the edge of the write.
- R9: A byte strobe and a data pop in the same cycle, with the queue neither empty nor full, leave the count unchanged. Storage positions wrap modulo 16, so arrival order is kept across the wrap.
- R10: Address 0 reads back control bits 10:6, with the other bits 0. Address 1 is a status register with no side effect: bit 0 is `data_ready`, bit 1 is `rx_full_flag`, bit 2 is `rx_ready`, and bits 12:8 are the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe: one received byte this cycle |
| rx_byte | input | DATA_W | Received byte |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe; read side effects occur at the clock edge |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 line status, 3 data |
| reg_wdata | input | BUS_W | Bus write data |
| reg_rdata | output | BUS_W | Bus read data, combinational from `reg_addr` |
| rx_full_flag | output | 1 | Count has reached the trigger level |
| data_ready | output | 1 | Data present but below the trigger level |
| rx_ready | output | 1 | Flow control: count is below the acceptance limit |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 16-entry queue and a 16-bit bus. With these values a single run can fill the queue to 16 and push one byte past it. It can also drive the pointers across the modulo-16 wrap while a push and a pop land in the same cycle. The table drives the trigger selections 4, 8 and 14 and the acceptance limits 15, 4 and 1, and it stores bytes while `rx_ready` is low. The directed part covers the two edges of trigger 14 and limit 15, and an overrun that coincides with a line status read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_LINE = 2'd2,
      ADDR_DATA = 2'd3
   } rx_reg_e;

   // control field positions
   localparam int TRIG_LSB = 6;
   localparam int ACC_LSB  = 8;

   function automatic int trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   function automatic int accept_limit(input logic [2:0] sel);
      if (sel == 3'd0)      return 15;
      else if (sel == 3'd1) return 1;
      else                  return 2 * int'(sel);
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  fill,
   output logic              ovf
);
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [DATA_W-1:0] slot [DEPTH];
   logic              do_push, do_pop;

   assign do_push = push && (fill != CNT_W'(DEPTH));
   assign do_pop  = pop  && (fill != '0);
   assign ovf     = push && (fill == CNT_W'(DEPTH));

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk)
         if (do_push && wr_ptr == PTR_W'(g)) q <= din;
      assign slot[g] = q;
   end

   assign head = (fill == '0) ? '0 : slot[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
   import serial_rx_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] fill,
   input  logic [1:0]       trig_sel,
   input  logic [2:0]       acc_sel,
   output logic             rx_full_flag,
   output logic             data_ready,
   output logic             rx_ready
);
   int level, limit, cnt;

   always_comb begin
      cnt          = int'(fill);
      level        = trig_level(trig_sel);
      limit        = accept_limit(acc_sel);
      rx_full_flag = (cnt >= level);
      data_ready   = !rx_full_flag && (cnt > 0);
      rx_ready     = (cnt < limit);
   end
endmodule

// File: rtl/rxf_overrun.sv
module rxf_overrun (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
   import serial_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int BUS_W  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              rx_full_flag,
   output logic              data_ready,
   output logic              rx_ready
);
   if (DEPTH < 15 || (1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (BUS_W < 8 + CNT_W || BUS_W < 11) begin : g_bad_bus
      $error("BUS_W too narrow for the status and control fields");
   end
   if (DATA_W > BUS_W) begin : g_bad_data
      $error("DATA_W must fit in BUS_W");
   end

   rx_reg_e          sel;
   logic [1:0]       trig_sel;
   logic [2:0]       acc_sel;
   logic [CNT_W-1:0] fill;
   logic [DATA_W-1:0] head;
   logic             ovf, overrun, pop;
   logic             unused_wbits;

   assign sel          = rx_reg_e'(reg_addr);
   assign pop          = reg_rd && sel == ADDR_DATA;
   assign unused_wbits = ^{reg_wdata[BUS_W-1:11], reg_wdata[5:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_sel <= '0;
         acc_sel  <= '0;
      end else if (reg_wr && sel == ADDR_CTRL) begin
         trig_sel <= reg_wdata[TRIG_LSB +: 2];
         acc_sel  <= reg_wdata[ACC_LSB  +: 3];
      end
   end

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte),
      .pop(pop), .head(head), .fill(fill), .ovf(ovf)
   );

   rxf_flags #(.CNT_W(CNT_W)) u_flags (
      .fill(fill), .trig_sel(trig_sel), .acc_sel(acc_sel),
      .rx_full_flag(rx_full_flag), .data_ready(data_ready), .rx_ready(rx_ready)
   );

   rxf_overrun u_ovr (
      .clk(clk), .rst_n(rst_n), .set(ovf),
      .clr(reg_rd && sel == ADDR_LINE), .q(overrun)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         ADDR_CTRL: begin
            reg_rdata[TRIG_LSB +: 2] = trig_sel;
            reg_rdata[ACC_LSB  +: 3] = acc_sel;
         end
         ADDR_STAT: begin
            reg_rdata[0]         = data_ready;
            reg_rdata[1]         = rx_full_flag;
            reg_rdata[2]         = rx_ready;
            reg_rdata[8 +: CNT_W] = fill;
         end
         ADDR_LINE: reg_rdata[0] = overrun;
         default:   reg_rdata[DATA_W-1:0] = head;
      endcase
   end
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             reg_rd,
   input logic [1:0]       reg_addr,
   input logic [CNT_W-1:0] fill,
   input logic             overrun,
   input logic             rx_full_flag,
   input logic             data_ready
);
   logic pop_req, line_rd, full, empty;
   assign pop_req = reg_rd && reg_addr == 2'd3;
   assign line_rd = reg_rd && reg_addr == 2'd2;
   assign full    = fill == CNT_W'(DEPTH);
   assign empty   = fill == '0;

   // R5
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full_flag && data_ready));

   // R6
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!data_ready && !rx_full_flag));

   // R3
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   // R3
   overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && full && !pop_req) |=> (full && overrun));

   // R4
   line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rd && !(rx_valid && full)) |=> !overrun);

   // R9
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && pop_req && !full && !empty) |=> $stable(fill));
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .fill(fill), .overrun(overrun),
   .rx_full_flag(rx_full_flag), .data_ready(data_ready)
);

// File: tb/tb_serial_rx_fifo.sv
`timescale 1ns/1ps
module tb_serial_rx_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rx_full_flag, data_ready, rx_ready;

   int tests = 0, fails = 0;
   logic [1:0] m_trig = '0;
   logic [2:0] m_acc = '0;

   always #4 clk = ~clk;

   serial_rx_fifo dut (.*);

   // op: 0 push arg byte, 1 control write arg, 2 pop expecting arg byte
   localparam logic [22:0] VEC [16] = '{
      {2'd1, 16'h0040, 5'd0},
      {2'd0, 16'h00A1, 5'd1},
      {2'd0, 16'h00A2, 5'd2},
      {2'd0, 16'h00A3, 5'd3},
      {2'd0, 16'h00A4, 5'd4},
      {2'd2, 16'h00A1, 5'd3},
      {2'd1, 16'h0280, 5'd3},
      {2'd0, 16'h00A5, 5'd4},
      {2'd0, 16'h00A6, 5'd5},
      {2'd1, 16'h01C0, 5'd5},
      {2'd2, 16'h00A2, 5'd4},
      {2'd2, 16'h00A3, 5'd3},
      {2'd2, 16'h00A4, 5'd2},
      {2'd2, 16'h00A5, 5'd1},
      {2'd2, 16'h00A6, 5'd0},
      {2'd2, 16'h0000, 5'd0}
   };

   function automatic int tb_trig(input logic [1:0] s);
      int t [4] = '{1, 4, 8, 14};
      return t[s];
   endfunction
   function automatic int tb_lim(input logic [2:0] s);
      int t [8] = '{15, 1, 4, 6, 8, 10, 12, 14};
      return t[s];
   endfunction

   task automatic chk(input int act, input int exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] wd, input logic v, input logic [7:0] b,
                      output logic [15:0] rdat);
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      rx_valid = v; rx_byte = b;
      #1 rdat = reg_rdata;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_rd = 1'b0; rx_valid = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      logic [15:0] d;
      cyc(1'b0, 1'b0, 2'd0, 16'h0, 1'b1, b, d);
   endtask

   task automatic rdreg(input logic [1:0] a, output logic [15:0] d);
      cyc(1'b0, 1'b1, a, 16'h0, 1'b0, 8'h0, d);
   endtask

   // count via status register plus pin flags against the model levels
   task automatic check_state(input int cnt, input string tag);
      logic [15:0] s;
      int rf, dr, rdy;
      rf  = (cnt >= tb_trig(m_trig)) ? 1 : 0;
      dr  = (rf == 0 && cnt > 0) ? 1 : 0;
      rdy = (cnt < tb_lim(m_acc)) ? 1 : 0;
      rdreg(2'd1, s);
      chk(int'(s[12:8]), cnt, {tag, " R10 count"});
      chk(int'(s[2:0]), rdy * 4 + rf * 2 + dr, {tag, " R10 status bits"});
      chk(int'(rx_full_flag), rf, {tag, " R5 rx_full_flag"});
      chk(int'(data_ready), dr, {tag, " R6 data_ready"});
      chk(int'(rx_ready), rdy, {tag, " R7 rx_ready"});
   endtask

   initial begin
      #(8 * 200000);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(int'({rx_full_flag, data_ready, rx_ready}), 1, "R1 pins after reset");
      rdreg(2'd2, d); chk(int'(d), 0, "R1 overrun clear");
      rdreg(2'd0, d); chk(int'(d), 0, "R1 control zero");
      check_state(0, "R1");

      // table walk: R2 R5 R6 R7 R8
      foreach (VEC[i]) begin
         logic [1:0]  op;
         logic [15:0] arg;
         op  = VEC[i][22:21];
         arg = VEC[i][20:5];
         case (op)
            2'd0: push(arg[7:0]);
            2'd1: begin
               cyc(1'b1, 1'b0, 2'd0, arg, 1'b0, 8'h0, d);
               m_trig = arg[7:6];
               m_acc  = arg[10:8];
            end
            default: begin
               rdreg(2'd3, d);
               chk(int'(d), int'(arg), $sformatf("R2 pop data vec %0d", i));
            end
         endcase
         check_state(int'(VEC[i][4:0]), $sformatf("R8 vec %0d", i));
      end
      rdreg(2'd0, d); chk(int'(d), 16'h01C0, "R10 control readback");

      // fill to 16 with trigger 14 and limit 15
      cyc(1'b1, 1'b0, 2'd0, 16'h00C0, 1'b0, 8'h0, d);
      m_trig = 2'd3; m_acc = 3'd0;
      for (int k = 0; k < 16; k++) begin
         push(8'h10 + 8'(k));
         if (k >= 12) check_state(k + 1, $sformatf("R5 R7 fill %0d", k + 1));
      end
      push(8'hEE);
      check_state(16, "R3 full after drop");
      rdreg(2'd2, d); chk(int'(d), 1, "R3 overrun set");
      rdreg(2'd2, d); chk(int'(d), 0, "R4 overrun cleared by read");

      // simultaneous push and pop across the wrap
      rdreg(2'd3, d); chk(int'(d), 8'h10, "R9 first byte");
      cyc(1'b0, 1'b1, 2'd3, 16'h0, 1'b1, 8'h55, d);
      chk(int'(d), 8'h11, "R9 pop during push");
      check_state(15, "R9 count unchanged");
      for (int k = 2; k < 16; k++) begin
         rdreg(2'd3, d);
         chk(int'(d), 8'h10 + k, $sformatf("R9 order %0d", k));
      end
      rdreg(2'd3, d); chk(int'(d), 8'h55, "R9 wrapped byte");
      check_state(0, "R2 drained");

      // overrun arriving with a line status read
      for (int k = 0; k < 17; k++) push(8'(k));
      cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b1, 8'h77, d);
      chk(int'(d), 1, "R4 read returns set bit");
      rdreg(2'd2, d); chk(int'(d), 1, "R4 new overrun wins over clear");
      rdreg(2'd2, d); chk(int'(d), 0, "R4 cleared afterwards");
      rdreg(2'd3, d); chk(int'(d), 0, "R3 oldest byte kept");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule